// File: doc/BRIEF.md
# Sequential City-Block Regression Evaluator

This block computes a clustered kernel-regression estimate by visiting a table of stored cluster centres one per clock. A host fills the table through a write port. Each entry holds a centre vector of `DIM` elements, a population count, and the count multiplied by that cluster's mean output. The host writes the product already in two's complement. When a new input sample arrives, the block shifts it into an input tap line. It then forms the query vector from the recent input samples and the recent outputs of the block. After that it scans every table entry.

An entry contributes only if all of its elements agree with the query in their upper bits. The number of low bits left out of the comparison is set by `lowbits`, which makes the kernel a flat box of half-width 2^L − 1 per dimension. An optional rule widens the ignored field by one bit for each element whose top ignored bit is set. The counts and the products of the matching entries are summed. A restoring divider then forms their quotient, and the result is returned as an offset-binary sample. A done pulse marks each result. A no-match flag marks a sweep in which no stored population was selected.

Top module: `cbr_regressor`

## Requirements
- R1: After reset, `busy` and `done` are 0, `no_match` is 0, `y_out` is 8'h80, and every tap of both delay lines holds 8'h80. Samples are offset binary: 8'h80 is zero, and larger codes are positive.
- R2: A write with `cfg_we`=1 stores centre, count and product at entry `cfg_addr`. Entries that have not been written since reset have count 0 and product 0, so they contribute nothing.
- R3: A sample is accepted when `in_valid`=1 and `busy`=0, and `busy` is 1 in the next cycle. `done` goes high on the clock edge DEPTH + N + 2 after the accepting edge, where N = CNT_W + BITS + clog2(DEPTH+1). With the default parameters this is 28 edges.
- R4: Element k of centre c matches query element x when x[k] >> L equals c[k] >> L. An entry is selected only if all DIM elements match.
- R5: With L = 0, only an exact centre matches. With L ≥ BITS, every entry is selected.
- R6: When `widen_en`=1 and L > 0, an element whose bit L−1 is 1 is compared with L+1 ignored bits. An element whose bit L−1 is 0 keeps L.
- R7: `y_out` equals (sum of selected products) / (sum of selected counts), truncated toward zero, plus 128, as an 8-bit offset-binary code. This holds for negative, positive and mixed sums.
- R8: If the selected count sum is 0, `y_out` is 8'h80 and `no_match` is 1. Otherwise `no_match` is 0.
- R9: Query element 0 is the newest accepted sample, and elements 1..DIM−EXT−1 are the older samples, newest first. Elements DIM−EXT..DIM−1 are the previous results, newest first.
- R10: `in_valid` while `busy`=1 is ignored. The sample enters no tap, and no extra result is produced.
- R11: `done` is high for exactly one cycle per accepted sample. `y_out` and `no_match` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | AW (3) | Table entry index |
| cfg_centre | input | DIM*BITS (32) | Centre vector, element k at bits [k*BITS +: BITS] |
| cfg_count | input | CNT_W (6) | Population count of the entry |
| cfg_prod | input | CNT_W+BITS (14) | Count times mean output, two's complement |
| lowbits | input | LW (4) | Number of ignored low bits L |
| widen_en | input | 1 | Enables the per-element one-bit widening rule |
| in_valid | input | 1 | New input sample present |
| in_sample | input | BITS (8) | Offset-binary input sample |
| busy | output | 1 | Sweep or division in progress |
| done | output | 1 | One-cycle pulse: new result on `y_out` |
| y_out | output | BITS (8) | Offset-binary estimate |
| no_match | output | 1 | Last sweep selected no population |

## Verification
Every result is due on a fixed edge. The accepting edge is followed by DEPTH sweep edges, one divider load edge, N divide edges and one output edge, so `done` rises exactly 28 edges after acceptance with the default parameters. The bench counts rising edges from the accepting edge and samples `done`, `y_out` and `no_match` at the falling edge that follows each one. It requires the first `done` on edge 28 exactly. It checks `busy` at the first falling edge after acceptance. It confirms the one-cycle pulse and the held outputs on the falling edge after `done`. Expected values come from a bench model of the tap lines and of the table.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_DIVS  = 2'd2,
    ST_DIVR  = 2'd3
  } cbr_state_e;
endpackage

// File: rtl/cbr_param_mem.sv
module cbr_param_mem #(
  parameter int BITS   = 8,
  parameter int DIM    = 4,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 6,
  parameter int PROD_W = 14,
  parameter int AW     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DIM*BITS-1:0]      wr_centre,
  input  logic [CNT_W-1:0]         wr_count,
  input  logic [PROD_W-1:0]        wr_prod,
  input  logic [AW-1:0]            rd_addr,
  output logic [DIM*BITS-1:0]      rd_centre,
  output logic [CNT_W-1:0]         rd_count,
  output logic [PROD_W-1:0]        rd_prod
);
  logic [DIM*BITS-1:0] cen_q  [DEPTH];
  logic [CNT_W-1:0]    cnt_q  [DEPTH];
  logic [PROD_W-1:0]   prod_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic ent_en;
    assign ent_en = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cen_q[g]  <= '0;
        cnt_q[g]  <= '0;
        prod_q[g] <= '0;
      end else if (ent_en) begin
        cen_q[g]  <= wr_centre;
        cnt_q[g]  <= wr_count;
        prod_q[g] <= wr_prod;
      end
    end
  end

  always_comb begin
    rd_centre = '0;
    rd_count  = '0;
    rd_prod   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_addr == AW'(i)) begin
        rd_centre = cen_q[i];
        rd_count  = cnt_q[i];
        rd_prod   = prod_q[i];
      end
    end
  end
endmodule

// File: rtl/cbr_match.sv
module cbr_match #(
  parameter int BITS = 8,
  parameter int DIM  = 4,
  parameter int LW   = 4
) (
  input  logic [DIM*BITS-1:0] x_vec,
  input  logic [DIM*BITS-1:0] c_vec,
  input  logic [LW-1:0]       lowbits,
  input  logic                widen_en,
  output logic                hit
);
  logic [DIM-1:0] elem_hit;

  for (genvar k = 0; k < DIM; k++) begin : g_elem
    logic [BITS-1:0] xk, ck, mask;
    logic            wide;
    logic [LW:0]     eff;
    assign xk = x_vec[k*BITS +: BITS];
    assign ck = c_vec[k*BITS +: BITS];
    always_comb begin
      wide = widen_en && (lowbits != '0) &&
             (|(xk & (BITS'(1) << (lowbits - LW'(1)))));
      eff  = {1'b0, lowbits} + (LW+1)'(wide);
      mask = {BITS{1'b1}} << eff;
      elem_hit[k] = ((xk ^ ck) & mask) == '0;
    end
  end

  assign hit = &elem_hit;
endmodule

// File: rtl/cbr_divider.sv
module cbr_divider #(
  parameter int NUM_W = 18,
  parameter int DEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic [NUM_W-1:0] quot,
  output logic             ready
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, rem_d, den_q, den_d;
  logic [NUM_W-1:0] q_q, q_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DEN_W:0]   trial;

  always_comb begin
    rem_d = rem_q;
    q_d   = q_q;
    den_d = den_q;
    cnt_d = cnt_q;
    trial = {rem_q, q_q[NUM_W-1]};
    if (start) begin
      rem_d = '0;
      q_d   = numer;
      den_d = denom;
      cnt_d = CW'(NUM_W);
    end else if (cnt_q != '0) begin
      if (trial >= {1'b0, den_q}) begin
        rem_d = DEN_W'(trial - {1'b0, den_q});
        q_d   = {q_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_d = trial[DEN_W-1:0];
        q_d   = {q_q[NUM_W-2:0], 1'b0};
      end
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      q_q   <= '0;
      den_q <= '0;
      cnt_q <= '0;
    end else begin
      rem_q <= rem_d;
      q_q   <= q_d;
      den_q <= den_d;
      cnt_q <= cnt_d;
    end
  end

  assign quot  = q_q;
  assign ready = (cnt_q == '0);
endmodule

// File: rtl/cbr_regressor.sv
module cbr_regressor #(
  parameter int BITS  = 8,
  parameter int DIM   = 4,
  parameter int EXT   = 1,
  parameter int DEPTH = 8,
  parameter int CNT_W = 6,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW     = $clog2(BITS + 1),
  localparam int PROD_W = CNT_W + BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [DIM*BITS-1:0] cfg_centre,
  input  logic [CNT_W-1:0]    cfg_count,
  input  logic [PROD_W-1:0]   cfg_prod,
  input  logic [LW-1:0]       lowbits,
  input  logic                widen_en,
  input  logic                in_valid,
  input  logic [BITS-1:0]     in_sample,
  output logic                busy,
  output logic                done,
  output logic [BITS-1:0]     y_out,
  output logic                no_match
);
  import cbr_pkg::*;

  localparam int NIN     = DIM - EXT;
  localparam int SUMW    = $clog2(DEPTH + 1);
  localparam int ACC_C_W = CNT_W + SUMW;
  localparam int ACC_P_W = PROD_W + SUMW;
  localparam logic [BITS-1:0] ZERO_CODE = BITS'(1) << (BITS - 1);
  localparam logic signed [ACC_P_W-1:0] Y_MAX = ACC_P_W'((1 << (BITS - 1)) - 1);
  localparam logic signed [ACC_P_W-1:0] Y_MIN = -ACC_P_W'(1 << (BITS - 1));

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  cbr_state_e state_q, state_d;
  logic [AW-1:0]             idx_q, idx_d;
  logic [ACC_C_W-1:0]        acc_c_q, acc_c_d;
  logic signed [ACC_P_W-1:0] acc_p_q, acc_p_d;
  logic [BITS-1:0]           in_q  [NIN];
  logic [BITS-1:0]           in_d  [NIN];
  logic [BITS-1:0]           out_q [EXT];
  logic [BITS-1:0]           out_d [EXT];
  logic [BITS-1:0]           y_q, y_d;
  logic                      nm_q, nm_d, done_q, done_d;

  logic [DIM*BITS-1:0] x_vec, rd_centre;
  logic [CNT_W-1:0]    rd_count;
  logic [PROD_W-1:0]   rd_prod;
  logic                hit;

  // query vector: input taps first, output taps after
  for (genvar k = 0; k < DIM; k++) begin : g_vec
    if (k < NIN) begin : g_in
      assign x_vec[k*BITS +: BITS] = in_q[k];
    end else begin : g_out
      assign x_vec[k*BITS +: BITS] = out_q[k - NIN];
    end
  end

  cbr_param_mem #(
    .BITS(BITS), .DIM(DIM), .DEPTH(DEPTH), .CNT_W(CNT_W), .PROD_W(PROD_W), .AW(AW)
  ) u_mem (
    .clk(clk), .rst_n(rst_sync),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_centre(cfg_centre),
    .wr_count(cfg_count), .wr_prod(cfg_prod),
    .rd_addr(idx_q), .rd_centre(rd_centre), .rd_count(rd_count), .rd_prod(rd_prod)
  );

  cbr_match #(.BITS(BITS), .DIM(DIM), .LW(LW)) u_match (
    .x_vec(x_vec), .c_vec(rd_centre), .lowbits(lowbits),
    .widen_en(widen_en), .hit(hit)
  );

  // sign-magnitude split around the divider
  logic                      acc_neg, div_start, div_ready;
  logic [ACC_P_W-1:0]        mag, quot;
  logic signed [ACC_P_W-1:0] q_s, q_sat;

  assign acc_neg = acc_p_q[ACC_P_W-1];
  assign mag     = acc_neg ? ACC_P_W'(-acc_p_q) : ACC_P_W'(acc_p_q);

  cbr_divider #(.NUM_W(ACC_P_W), .DEN_W(ACC_C_W)) u_div (
    .clk(clk), .rst_n(rst_sync), .start(div_start),
    .numer(mag), .denom(acc_c_q), .quot(quot), .ready(div_ready)
  );

  always_comb begin
    q_s = acc_neg ? -$signed(quot) : $signed(quot);
    if (q_s > Y_MAX)      q_sat = Y_MAX;
    else if (q_s < Y_MIN) q_sat = Y_MIN;
    else                  q_sat = q_s;
  end

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    acc_c_d   = acc_c_q;
    acc_p_d   = acc_p_q;
    in_d      = in_q;
    out_d     = out_q;
    y_d       = y_q;
    nm_d      = nm_q;
    done_d    = 1'b0;
    div_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          in_d[0] = in_sample;
          for (int k = 1; k < NIN; k++) in_d[k] = in_q[k-1];
          acc_c_d = '0;
          acc_p_d = '0;
          idx_d   = '0;
          state_d = ST_SWEEP;
        end
      end
      ST_SWEEP: begin
        if (hit) begin
          acc_c_d = acc_c_q + ACC_C_W'(rd_count);
          acc_p_d = acc_p_q + $signed({{SUMW{rd_prod[PROD_W-1]}}, rd_prod});
        end
        if (idx_q == AW'(DEPTH - 1)) state_d = ST_DIVS;
        else                         idx_d   = idx_q + AW'(1);
      end
      ST_DIVS: begin
        div_start = 1'b1;
        state_d   = ST_DIVR;
      end
      ST_DIVR: begin
        if (div_ready) begin
          if (acc_c_q == '0) begin
            y_d  = ZERO_CODE;
            nm_d = 1'b1;
          end else begin
            y_d  = q_sat[BITS-1:0] ^ ZERO_CODE;
            nm_d = 1'b0;
          end
          out_d[0] = y_d;
          for (int e = 1; e < EXT; e++) out_d[e] = out_q[e-1];
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      acc_c_q <= '0;
      acc_p_q <= '0;
      for (int k = 0; k < NIN; k++) in_q[k]  <= ZERO_CODE;
      for (int e = 0; e < EXT; e++) out_q[e] <= ZERO_CODE;
      y_q     <= ZERO_CODE;
      nm_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      acc_c_q <= acc_c_d;
      acc_p_q <= acc_p_d;
      in_q    <= in_d;
      out_q   <= out_d;
      y_q     <= y_d;
      nm_q    <= nm_d;
      done_q  <= done_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign y_out    = y_q;
  assign no_match = nm_q;
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
  parameter int BITS    = 8,
  parameter int ACC_C_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               busy,
  input logic               done,
  input logic               no_match,
  input logic [BITS-1:0]    y_out,
  input logic               sweeping,
  input logic [ACC_C_W-1:0] acc_c,
  input logic [BITS-1:0]    tap0
);
  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> busy);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(y_out) && $stable(no_match)));

  p_nomatch_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_match) |-> (y_out == {1'b1, {(BITS-1){1'b0}}}));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |=> $stable(tap0));

  p_count_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sweeping |=> (acc_c >= $past(acc_c)));
endmodule

bind cbr_regressor cbr_checker #(
  .BITS(BITS), .ACC_C_W(ACC_C_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync), .in_valid(in_valid), .busy(busy),
  .done(done), .no_match(no_match), .y_out(y_out),
  .sweeping(state_q == cbr_pkg::ST_SWEEP), .acc_c(acc_c_q), .tap0(in_q[0])
);

// File: tb/tb_cbr_regressor.sv
`timescale 1ns/1ps
module tb_cbr_regressor;
  localparam int BITS = 8, DIM = 4, EXT = 1, DEPTH = 8, CNT_W = 6;
  localparam int NIN = DIM - EXT, AW = 3, LW = 4, PROD_W = CNT_W + BITS;
  localparam int NQ  = CNT_W + BITS + $clog2(DEPTH + 1);
  localparam int LAT = DEPTH + NQ + 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [DIM*BITS-1:0] cfg_centre;
  logic [CNT_W-1:0] cfg_count;
  logic [PROD_W-1:0] cfg_prod;
  logic [LW-1:0] lowbits;
  logic widen_en, in_valid;
  logic [BITS-1:0] in_sample;
  logic busy, done, no_match;
  logic [BITS-1:0] y_out;

  always #2.5 clk = ~clk;

  cbr_regressor dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_centre(cfg_centre), .cfg_count(cfg_count), .cfg_prod(cfg_prod),
    .lowbits(lowbits), .widen_en(widen_en), .in_valid(in_valid),
    .in_sample(in_sample), .busy(busy), .done(done), .y_out(y_out),
    .no_match(no_match)
  );

  int n_chk = 0, n_fail = 0;
  logic [DIM*BITS-1:0] m_cen [DEPTH];
  int m_cnt [DEPTH], m_prod [DEPTH], m_in [NIN], m_out [EXT];
  int m_l = 0;
  bit m_w = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(int i, logic [DIM*BITS-1:0] c, int cnt, int yob);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(i); cfg_centre = c;
    cfg_count = CNT_W'(cnt); cfg_prod = PROD_W'(cnt * (yob - 128));
    @(negedge clk);
    cfg_we = 1'b0;
    m_cen[i] = c; m_cnt[i] = cnt; m_prod[i] = cnt * (yob - 128);
  endtask

  task automatic set_mode(int l, bit w);
    @(negedge clk);
    lowbits = LW'(l); widen_en = w; m_l = l; m_w = w;
  endtask

  function automatic logic [DIM*BITS-1:0] pred(int s);
    logic [DIM*BITS-1:0] v;
    v[0 +: BITS] = BITS'(s);
    for (int k = 1; k < NIN; k++) v[k*BITS +: BITS] = BITS'(m_in[k-1]);
    for (int e = 0; e < EXT; e++) v[(NIN+e)*BITS +: BITS] = BITS'(m_out[e]);
    return v;
  endfunction

  task automatic model(logic [DIM*BITS-1:0] v, output int y, output int nm);
    int sc, sp;
    sc = 0; sp = 0;
    for (int i = 0; i < DEPTH; i++) begin
      bit sel;
      sel = 1;
      for (int k = 0; k < DIM; k++) begin
        int x, c, eff;
        x = int'(v[k*BITS +: BITS]);
        c = int'(m_cen[i][k*BITS +: BITS]);
        eff = m_l;
        if (m_w && m_l > 0 && ((x >> (m_l - 1)) & 1) == 1) eff++;
        if (eff < BITS && (x >> eff) != (c >> eff)) sel = 0;
      end
      if (sel) begin sc += m_cnt[i]; sp += m_prod[i]; end
    end
    if (sc == 0) begin y = 128; nm = 1; end
    else begin y = ((sp / sc) + 128) & 255; nm = 0; end
  endtask

  task automatic run(int s, string req, bit inject);
    int ey, en, k;
    bit got;
    model(pred(s), ey, en);
    @(negedge clk);
    in_sample = BITS'(s); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(busy == 1'b1, "R3 busy after accept", int'(busy), 1);
    k = 0; got = 0;
    while (k < LAT + 40 && !got) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (inject && k == 3) begin in_valid = 1'b1; in_sample = ~BITS'(s); end
      else in_valid = 1'b0;
      if (done) got = 1;
    end
    chk(k == LAT, "R3 latency", k, LAT);
    chk(int'(y_out) == ey, req, int'(y_out), ey);
    chk(int'(no_match) == en, "R8 no_match", int'(no_match), en);
    @(negedge clk);
    chk(done == 1'b0, "R11 single pulse", int'(done), 0);
    chk(int'(y_out) == ey, "R11 hold", int'(y_out), ey);
    for (int j = NIN - 1; j > 0; j--) m_in[j] = m_in[j-1];
    m_in[0] = s;
    for (int e = EXT - 1; e > 0; e--) m_out[e] = m_out[e-1];
    m_out[0] = ey;
  endtask

  task automatic setup_single(int s, int elem, int flip, int yob);
    logic [DIM*BITS-1:0] v;
    v = pred(s);
    v[elem*BITS +: BITS] = v[elem*BITS +: BITS] ^ BITS'(flip);
    load(0, v, 5, yob);
    for (int i = 1; i < DEPTH; i++) load(i, '0, 0, 128);
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(no_match == 1'b0, "R1 no_match", int'(no_match), 0);
    chk(y_out == 8'h80, "R1 y_out", int'(y_out), 128);
  endtask

  task automatic t_empty;
    set_mode(8, 0);
    run(8'h35, "R2 empty table", 0);
  endtask

  task automatic t_all;
    for (int i = 0; i < DEPTH; i++) load(i, DIM*BITS'(i * 32'h1357), i + 1, 20 + i * 29);
    set_mode(8, 0);
    run(8'hA0, "R5 all selected", 0);
    for (int i = 0; i < DEPTH; i++) load(i, '0, 3 + i, 40 + (i % 3) * 37);
    run(8'h10, "R7 negative sum", 0);
    for (int i = 0; i < DEPTH; i++) load(i, '0, 7 - (i % 4), (i % 2) ? 250 : 3);
    run(8'hF0, "R7 mixed sum", 0);
  endtask

  task automatic t_exact;
    set_mode(0, 0);
    setup_single(8'h6B, 0, 0, 200);
    run(8'h6B, "R9 vector order exact", 0);
    setup_single(8'h22, 3, 1, 60);
    run(8'h22, "R5 L0 one bit off", 0);
    setup_single(8'h47, 1, 0, 90);
    run(8'h47, "R9 older taps", 0);
  endtask

  task automatic t_upper;
    set_mode(3, 0);
    setup_single(8'h58, 1, 8'h04, 170);
    run(8'h58, "R4 low field ignored", 0);
    setup_single(8'h58, 2, 8'h08, 170);
    run(8'h58, "R4 upper bit differs", 0);
  endtask

  task automatic t_widen;
    set_mode(2, 0);
    setup_single(8'h93, 0, 8'h04, 30);
    run(8'h93, "R6 widen off", 0);
    set_mode(2, 1);
    setup_single(8'h93, 0, 8'h04, 30);
    run(8'h93, "R6 widen on bit set", 0);
    setup_single(8'h91, 0, 8'h04, 30);
    run(8'h91, "R6 widen on bit clear", 0);
  endtask

  task automatic t_busy;
    set_mode(8, 0);
    load(0, '0, 4, 140);
    run(8'h2C, "R10 accepted sample", 1);
    set_mode(0, 0);
    setup_single(8'h7E, 0, 0, 77);
    run(8'h7E, "R10 busy sample ignored", 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_centre = '0;
    cfg_count = '0; cfg_prod = '0; lowbits = '0; widen_en = 1'b0;
    in_valid = 1'b0; in_sample = '0;
    for (int i = 0; i < DEPTH; i++) begin m_cen[i] = '0; m_cnt[i] = 0; m_prod[i] = 0; end
    for (int k = 0; k < NIN; k++) m_in[k] = 128;
    for (int e = 0; e < EXT; e++) m_out[e] = 128;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_empty();
    t_all();
    t_exact();
    t_upper();
    t_widen();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule